// File: doc/BRIEF.md
# Paged 32-bit Register Access over MDIO

This block lets on-chip logic read and write 32-bit registers inside a device that is reachable only through a standard Clause 22 MDIO management bus. The remote registers use a 16-bit byte address. Each register is word aligned, so the two lowest address bits carry no meaning.

One 32-bit access becomes three MDIO frames, sent in a fixed order:
- a page-select write that carries address bits 15:6;
- a frame for data bits 15:0, whose 5-bit register field holds address bits 5:2;
- a frame for data bits 31:16, sent to a fixed register field.

The page frame is sent again on every access, with no cache of the last page. The block contains its own MDIO master. That master generates MDC and drives the data line through a separate output-enable.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The requester must hold the request steady until it is taken, and nothing is dropped. The result comes back as a single-cycle `rsp_valid` pulse with no back-pressure, so the requester must take `rsp_rdata` in that cycle. `req_ready` is high again in the same cycle as the pulse.

Top module: `paged_mdio_accessor`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low from that point until the access's `rsp_valid` pulse. A request held while not ready is taken later, and its frames reflect its own fields.
- R3: Every access sends exactly three frames, in this order: page, low half, high half. The page frame is resent even when two accesses share a page.
- R4: Each frame is sent MSB first and has this layout:
  - 32 preamble ones;
  - start bits 01;
  - a 2-bit opcode (01 write, 10 read);
  - the 5-bit target address given by parameter `PHY_ADDR` (default 0x1F);
  - a 5-bit register field;
  - a turnaround of 10 on write frames;
  - 16 data bits.
- R5: The page frame is a write to register field 11111 with data {6'b000000, addr[15:6]}. It is the same for reads and writes.
- R6: The low-half frame uses register field {0, addr[5:2]}. Its opcode is 10 for a read and 01 for a write. On a write it carries wdata[15:0].
- R7: The high-half frame uses register field 10000 and the same opcode as the low-half frame. On a write it carries wdata[31:16].
- R8: addr[1:0] has no effect on any frame.
- R9: Read data is returned as follows:
  - On read frames the block releases the line (`mdio_oe` = 0) from the turnaround through the data bits.
  - `rsp_valid` is a one-cycle pulse issued after the third frame ends.
  - `rsp_rdata` is {high-frame data, low-frame data} for a read and 0 for a write.
- R10: MDC has the following timing:
  - Its period is 2*`MDC_HALF` clock cycles and it stays low between frames.
  - `mdio_o` changes only as MDC falls.
  - `mdio_i` is sampled in the last clock of MDC's high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of the 32-bit register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data (0 after a write), valid with `rsp_valid` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Most internal faults show up on the serial line within one frame. A wrong bit counter or wrong shift register corrupts the start bits, register field or data of the next frame that follows preamble. A fault in the phase sequencer shows up either as a missing or reordered frame among the three, or as a response pulse that arrives too early or too late. Turnaround handling is checked by a target model that drives the line. That model flags any cycle in which both sides drive. A wrong half-word in the read assembly appears directly in `rsp_rdata` at the pulse.

// File: rtl/mdio_acc_pkg.sv
package mdio_acc_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;

  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [4:0] REG_PAGE = 5'b11111;
  localparam logic [4:0] REG_HIGH = 5'b10000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE_GO,
    ST_PAGE_WAIT,
    ST_LOW_GO,
    ST_LOW_WAIT,
    ST_HIGH_GO,
    ST_HIGH_WAIT
  } acc_state_t;

  typedef enum logic [1:0] {
    SEL_PAGE,
    SEL_LOW,
    SEL_HIGH
  } frame_sel_t;

  typedef struct packed {
    logic              rd;
    logic [4:0]        regad;
    logic [HALF_W-1:0] data;
  } frame_req_t;

endpackage

// File: rtl/mdio_phase_map.sv
module mdio_phase_map
  import mdio_acc_pkg::*;
(
  input  frame_sel_t        sel,
  input  logic              is_write,
  input  logic [ADDR_W-1:2] word_addr,
  input  logic [DATA_W-1:0] wdata,
  output frame_req_t        freq
);

  localparam int PAGE_LSB = 6;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;

  always_comb begin
    unique case (sel)
      SEL_LOW: begin
        freq.rd    = !is_write;
        freq.regad = {1'b0, word_addr[PAGE_LSB-1:2]};
        freq.data  = wdata[HALF_W-1:0];
      end
      SEL_HIGH: begin
        freq.rd    = !is_write;
        freq.regad = REG_HIGH;
        freq.data  = wdata[DATA_W-1:HALF_W];
      end
      default: begin
        freq.rd    = 1'b0;
        freq.regad = REG_PAGE;
        freq.data  = {{(HALF_W-PAGE_W){1'b0}}, word_addr[ADDR_W-1:PAGE_LSB]};
      end
    endcase
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_acc_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h1F,
  parameter int         MDC_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_req_t        freq,
  output logic              busy,
  output logic              done,
  output logic [HALF_W-1:0] rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam int         PRE_BITS  = 32;
  localparam int         FRAME_W   = 64;
  localparam int         CNT_W     = (2 * MDC_HALF > 2) ? $clog2(2 * MDC_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_RISE = CNT_W'(MDC_HALF - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * MDC_HALF - 1);
  localparam logic [5:0] TA_POS   = 6'd46;
  localparam logic [5:0] DATA_POS = 6'd48;
  localparam logic [5:0] LAST_BIT = 6'd63;

  logic [CNT_W-1:0]  cnt;
  logic [5:0]        bit_idx;
  logic [FRAME_W-1:0] shreg;
  logic              rd_q;
  logic              mdc_q;
  logic              done_q;
  logic [HALF_W-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      rd_q    <= 1'b0;
      mdc_q   <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        cnt     <= '0;
        bit_idx <= '0;
        mdc_q   <= 1'b0;
        if (start) begin
          busy  <= 1'b1;
          rd_q  <= freq.rd;
          shreg <= {{PRE_BITS{1'b1}}, 2'b01, (freq.rd ? OP_RD : OP_WR),
                    PHY_ADDR, freq.regad, 2'b10, freq.data};
        end
      end else begin
        if (cnt == CNT_RISE) mdc_q <= 1'b1;
        if (cnt == CNT_LAST) begin
          mdc_q <= 1'b0;
          cnt   <= '0;
          if (rd_q && bit_idx >= DATA_POS) rx_q <= {rx_q[HALF_W-2:0], mdio_i};
          if (bit_idx == LAST_BIT) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 6'd1;
            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign done    = done_q;
  assign rdata   = rx_q;
  assign mdc     = mdc_q;
  assign mdio_o  = shreg[FRAME_W-1];
  assign mdio_oe = busy && !(rd_q && bit_idx >= TA_POS);

  assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_mdc_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> busy);
  assert_done_ends_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));
  assert_bit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && bit_idx != $past(bit_idx)) |-> bit_idx == $past(bit_idx) + 6'd1);

endmodule

// File: rtl/paged_mdio_accessor.sv
module paged_mdio_accessor
  import mdio_acc_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h1F,
  parameter int         MDC_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  acc_state_t        state;
  logic              wr_q;
  logic [ADDR_W-1:2] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [HALF_W-1:0] lo_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  frame_sel_t        sel;
  frame_req_t        fm_req;
  logic              fm_start;
  logic              fm_busy;
  logic              fm_done;
  logic [HALF_W-1:0] fm_rdata;

  always_comb begin
    unique case (state)
      ST_LOW_GO, ST_LOW_WAIT:   sel = SEL_LOW;
      ST_HIGH_GO, ST_HIGH_WAIT: sel = SEL_HIGH;
      default:                  sel = SEL_PAGE;
    endcase
  end

  assign fm_start  = (state == ST_PAGE_GO) || (state == ST_LOW_GO) || (state == ST_HIGH_GO);
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      lo_q        <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          addr_q  <= req_addr[ADDR_W-1:2];
          wdata_q <= req_wdata;
          state   <= ST_PAGE_GO;
        end
        ST_PAGE_GO:   state <= ST_PAGE_WAIT;
        ST_PAGE_WAIT: if (fm_done) state <= ST_LOW_GO;
        ST_LOW_GO:    state <= ST_LOW_WAIT;
        ST_LOW_WAIT: if (fm_done) begin
          lo_q  <= fm_rdata;
          state <= ST_HIGH_GO;
        end
        ST_HIGH_GO:   state <= ST_HIGH_WAIT;
        ST_HIGH_WAIT: if (fm_done) begin
          rsp_valid_q <= 1'b1;
          rsp_rdata_q <= wr_q ? '0 : {fm_rdata, lo_q};
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  mdio_phase_map u_map (
    .sel       (sel),
    .is_write  (wr_q),
    .word_addr (addr_q),
    .wdata     (wdata_q),
    .freq      (fm_req)
  );

  mdio_frame_engine #(
    .PHY_ADDR (PHY_ADDR),
    .MDC_HALF (MDC_HALF)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fm_start),
    .freq    (fm_req),
    .busy    (fm_busy),
    .done    (fm_done),
    .rdata   (fm_rdata),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .mdio_i  (mdio_i)
  );

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_rsp_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(fm_done));
  assert_page_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (fm_start && !fm_req.rd && fm_req.regad == REG_PAGE));
  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fm_busy |-> !req_ready);

endmodule

// File: tb/paged_mdio_accessor_bench.sv
module paged_mdio_accessor_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #4 clk = ~clk;

  paged_mdio_accessor #(.PHY_ADDR(5'h1F), .MDC_HALF(2)) u_paged_mdio_accessor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // ---------------- MDIO target model ----------------
  logic        tgt_drv = 1'b0;
  logic        tgt_bit = 1'b1;
  logic [15:0] tgt_lo = '0;
  logic [15:0] tgt_hi = '0;
  int          ones = 0;
  int          fpos = -1;
  logic [31:0] fsr = '0;
  logic        trd = 1'b0;
  logic [4:0]  treg = '0;
  int          contention = 0;
  int          nfr = 0;
  logic [31:0] lg [0:63];

  assign mdio_i = tgt_drv ? tgt_bit : 1'b1;

  // frame word from start bits: [31:30] ST [29:28] OP [27:23] PHY [22:18] REG [17:16] TA [15:0] DATA
  always @(posedge mdc) begin
    logic b;
    b = mdio_oe ? mdio_o : mdio_i;
    if (mdio_oe && tgt_drv) contention++;
    if (fpos < 0) begin
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o && ones >= 32) begin
        fsr = 32'd0; fpos = 1; trd = 1'b0;
      end else ones = 0;
    end else begin
      fsr = {fsr[30:0], b};
      fpos++;
      if (fpos == 4) trd = (fsr[1:0] == 2'b10);
      if (fpos == 14) treg = fsr[4:0];
      if (fpos == 32) begin
        lg[nfr] = fsr;
        nfr++;
        fpos = -1;
        ones = 0;
      end
    end
  end

  always @(negedge mdc) begin
    if (fpos >= 15 && trd) begin
      tgt_drv <= 1'b1;
      if (fpos == 15) tgt_bit <= 1'b0;
      else tgt_bit <= treg[4] ? tgt_hi[31-fpos] : tgt_lo[31-fpos];
    end else begin
      tgt_drv <= 1'b0;
      tgt_bit <= 1'b1;
    end
  end

  // ---------------- MDC period monitor ----------------
  time last_rise = 0;
  bit  seen_rise = 1'b0;
  int  short_per = 0;
  int  nominal_per = 0;

  always @(posedge mdc) begin
    if (seen_rise) begin
      if ($time - last_rise < 32) short_per++;
      else if ($time - last_rise == 32) nominal_per++;
    end
    seen_rise = 1'b1;
    last_rise = $time;
  end

  // ---------------- helpers ----------------
  task automatic issue(input logic wr, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [31:0] d);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    @(negedge clk);
    chk("R9 rsp_valid single cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic check_frames(int base, logic wr, logic [15:0] a, logic [31:0] d);
    logic [1:0] op;
    op = wr ? 2'b01 : 2'b10;
    for (int k = 0; k < 3; k++) begin
      chk("R4 start bits", {30'd0, lg[base+k][31:30]}, 32'd1);
      chk("R4 target address", {27'd0, lg[base+k][27:23]}, 32'h1F);
    end
    chk("R5 page opcode", {30'd0, lg[base][29:28]}, 32'd1);
    chk("R5 page register", {27'd0, lg[base][22:18]}, 32'h1F);
    chk("R5 page data", {16'd0, lg[base][15:0]}, {16'd0, 6'd0, a[15:6]});
    chk("R4 page turnaround", {30'd0, lg[base][17:16]}, 32'd2);
    chk("R6 low opcode", {30'd0, lg[base+1][29:28]}, {30'd0, op});
    chk("R6 low register", {27'd0, lg[base+1][22:18]}, {27'd0, 1'b0, a[5:2]});
    chk("R7 high opcode", {30'd0, lg[base+2][29:28]}, {30'd0, op});
    chk("R7 high register", {27'd0, lg[base+2][22:18]}, 32'h10);
    if (wr) begin
      chk("R6 low data", {16'd0, lg[base+1][15:0]}, {16'd0, d[15:0]});
      chk("R7 high data", {16'd0, lg[base+2][15:0]}, {16'd0, d[31:16]});
      chk("R4 write turnaround", {30'd0, lg[base+2][17:16]}, 32'd2);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 mdc", {31'd0, mdc}, 32'd0);
    chk("R1 mdio_oe", {31'd0, mdio_oe}, 32'd0);
  endtask

  task automatic t_write();
    int base; logic [31:0] d;
    base = nfr;
    issue(1'b1, 16'h1234, 32'hDEADBEEF);
    wait_rsp(d);
    chk("R9 write returns zero", d, 32'd0);
    chk("R3 three frames per write", nfr - base, 32'd3);
    check_frames(base, 1'b1, 16'h1234, 32'hDEADBEEF);
  endtask

  task automatic t_read();
    int base; logic [31:0] d;
    base = nfr;
    tgt_lo = 16'hA5C3; tgt_hi = 16'h0F1E;
    issue(1'b0, 16'hFFFC, 32'h0);
    wait_rsp(d);
    chk("R9 read data assembly", d, 32'h0F1EA5C3);
    chk("R3 three frames per read", nfr - base, 32'd3);
    chk("R9 no line contention", contention, 32'd0);
    check_frames(base, 1'b0, 16'hFFFC, 32'h0);
  endtask

  task automatic t_low_bits();
    int base; logic [31:0] d1, d2;
    base = nfr;
    tgt_lo = 16'h1357; tgt_hi = 16'h2468;
    issue(1'b0, 16'h0123, 32'h0);
    wait_rsp(d1);
    issue(1'b0, 16'h0120, 32'h0);
    wait_rsp(d2);
    for (int k = 0; k < 3; k++)
      chk("R8 addr[1:0] ignored", lg[base+k], lg[base+3+k]);
    chk("R8 same read data", d1, d2);
  endtask

  task automatic t_same_page();
    int base; logic [31:0] d;
    base = nfr;
    issue(1'b1, 16'h0040, 32'h11112222);
    wait_rsp(d);
    issue(1'b1, 16'h0044, 32'h33334444);
    wait_rsp(d);
    chk("R3 six frames for two accesses", nfr - base, 32'd6);
    chk("R3 page resent on same page", {27'd0, lg[base+3][22:18]}, 32'h1F);
    check_frames(base + 3, 1'b1, 16'h0044, 32'h33334444);
  endtask

  task automatic t_hold();
    int base; logic [31:0] d;
    base = nfr;
    issue(1'b1, 16'hABC0, 32'hCAFEF00D);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h5678; req_wdata = 32'h0BADC0DE;
    chk("R2 not ready while busy", {31'd0, req_ready}, 32'd0);
    wait_rsp(d);
    req_valid = 1'b0;
    chk("R2 held request taken", {31'd0, req_ready}, 32'd0);
    wait_rsp(d);
    chk("R2 both accesses sent", nfr - base, 32'd6);
    check_frames(base, 1'b1, 16'hABC0, 32'hCAFEF00D);
    check_frames(base + 3, 1'b1, 16'h5678, 32'h0BADC0DE);
  endtask

  task automatic t_mdc();
    repeat (4) @(negedge clk);
    chk("R10 mdc low when idle", {31'd0, mdc}, 32'd0);
    chk("R10 no short mdc period", short_per, 32'd0);
    chk("R10 nominal mdc period seen", {31'd0, nominal_per > 0}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_low_bits();
    t_same_page();
    t_hold();
    t_mdc();
    report();
  end

endmodule